// File: doc/BRIEF.md
# SENT Frame Receiver

This block receives frames on a single-wire SENT sensor line. The line is brought into the clock domain through a two-flop synchronizer and is sampled only on cycles where a tick-rate enable is high. The block counts the ticks between consecutive falling edges and searches for a synchronization interval close to 56 ticks. When it finds one, it treats the next eight intervals as the status symbol, six data symbols and the checksum symbol.

Each symbol interval is converted to a nibble by subtracting 12 ticks. The checksum is then recomputed over the six data nibbles and compared with the received one. A frame that passes the check updates the registered status and data outputs and raises a one-cycle valid strobe. A checksum mismatch, a symbol width out of range or a counter overflow each discard the frame and send the receiver back to sync search. Frames from one sensor can be told apart by the status nibble.

Top module: `sent_rx`

## Requirements
- R1: While rst_ni is low, and after its release until the first decoded frame, frame_valid_o, crc_error_o and symbol_error_o are 0, and status_o, data_a_o and data_b_o are all zero.
- R2: A falling-edge interval is measured in ticks. Only cycles with tick_i high sample the line and advance the count, so a frame whose edges lie N ticks apart decodes the same whatever the number of clock cycles per tick.
- R3: In sync search, an interval is accepted as sync only if it lies between 45 and 67 ticks inclusive, which is 56 ticks ±20 % with the deviation truncated to whole ticks. A frame that starts with a 44-tick or 68-tick interval produces no strobe of any kind.
- R4: Each symbol interval of W ticks encodes the nibble W−12. The first symbol after sync goes to status_o. data_a_o is formed from data nibbles 1, 2 and 3, and data_b_o from data nibbles 4, 5 and 6, with the earliest nibble in bits [11:8].
- R5: The checksum is a 4-bit CRC over the six data nibbles in arrival order, with seed 0101 and polynomial x^4+x^3+x^2+1, followed by one extra zero nibble. On a match, frame_valid_o goes high for exactly one cycle, in the same cycle as the new outputs.
- R6: On a checksum mismatch, crc_error_o goes high for one cycle, frame_valid_o stays low, and status_o, data_a_o and data_b_o keep their previous values.
- R7: A symbol interval under 12 or over 27 ticks raises symbol_error_o for one cycle and returns the block to sync search. A correct frame that follows is decoded normally.
- R8: If the line shows no falling edge for 255 ticks (with the default 8-bit counter), any frame in progress is dropped without a strobe and the block returns to sync search.
- R9: At most one of frame_valid_o, crc_error_o and symbol_error_o is high in any cycle. The decoded outputs change only in a cycle in which frame_valid_o is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Tick-rate enable for line sampling and interval counting |
| sent_i | input | 1 | Asynchronous SENT line |
| frame_valid_o | output | 1 | One-cycle strobe for a frame that passed the checksum |
| crc_error_o | output | 1 | One-cycle strobe for a checksum mismatch |
| symbol_error_o | output | 1 | One-cycle strobe for a symbol width out of range |
| status_o | output | 4 | Status nibble of the last valid frame |
| data_a_o | output | 12 | Data nibbles 1 to 3 of the last valid frame |
| data_b_o | output | 12 | Data nibbles 4 to 6 of the last valid frame |

## Verification
An interval counter that is off by one tick shifts every decoded nibble by one. That error reaches status_o and the data outputs a few cycles after the frame's closing edge, and it usually shows up as a crc_error_o strobe in place of a valid one. A capture index that slips or fails to reset after an abort puts nibbles in the wrong fields. It can also make the receiver treat a symbol as sync, which loses the next frame or raises a spurious symbol_error_o within one frame time. Sync windows one tick too wide or too narrow show at once on the 44, 45, 67 and 68 tick frames.

// File: rtl/sent_rx_pkg.sv
package sent_rx_pkg;
  localparam int NIB_W      = 4;
  localparam int DATA_NIBS  = 6;
  localparam int NIB_OFS    = 12;
  localparam int NIB_LAST   = NIB_OFS + (1 << NIB_W) - 1;
  localparam logic [3:0] CRC_SEED = 4'h5;
  localparam logic [3:0] CRC_POLY = 4'hD;  // x^4+x^3+x^2+1 without x^4 term

  typedef enum logic {ST_SEARCH, ST_CAPTURE} rx_state_e;

  // remainder of (c * x^4 + n) mod poly
  function automatic logic [3:0] crc4_step(input logic [3:0] c, input logic [3:0] n);
    logic [3:0] r;
    r = c;
    for (int b = 0; b < 4; b++) begin
      r = r[3] ? ({r[2:0], 1'b0} ^ CRC_POLY) : {r[2:0], 1'b0};
    end
    return r ^ n;
  endfunction
endpackage

// File: rtl/sent_edge_timer.sv
module sent_edge_timer #(
  parameter int CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             line_i,
  output logic             per_vld_o,
  output logic [CNT_W-1:0] per_o,
  output logic             ovf_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [1:0]       sync_q;
  logic             prev_q;
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q    <= 2'b11;
      prev_q    <= 1'b1;
      cnt_q     <= '0;
      per_vld_o <= 1'b0;
      per_o     <= '0;
      ovf_o     <= 1'b0;
    end else begin
      sync_q    <= {sync_q[0], line_i};
      per_vld_o <= 1'b0;
      ovf_o     <= 1'b0;
      if (tick_i) begin
        prev_q <= sync_q[1];
        if (prev_q && !sync_q[1]) begin
          per_vld_o <= 1'b1;
          per_o     <= (cnt_q == CNT_MAX) ? CNT_MAX : cnt_q + 1'b1;
          cnt_q     <= '0;
        end else if (cnt_q != CNT_MAX) begin
          cnt_q <= cnt_q + 1'b1;
          if (cnt_q == CNT_MAX - 1'b1) ovf_o <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/sent_crc4.sv
module sent_crc4
  import sent_rx_pkg::*;
#(
  parameter int NUM = DATA_NIBS
) (
  input  logic [NUM*NIB_W-1:0] nib_i,  // first nibble in the top bits
  output logic [3:0]           crc_o
);
  always_comb begin
    logic [3:0] c;
    c = CRC_SEED;
    for (int i = 0; i < NUM; i++) begin
      c = crc4_step(c, nib_i[(NUM-1-i)*NIB_W +: NIB_W]);
    end
    crc_o = crc4_step(c, 4'h0);
  end
endmodule

// File: rtl/sent_frame_fsm.sv
module sent_frame_fsm
  import sent_rx_pkg::*;
#(
  parameter int CNT_W    = 8,
  parameter int SYNC_MIN = 45,
  parameter int SYNC_MAX = 67
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       per_vld_i,
  input  logic [CNT_W-1:0]           per_i,
  input  logic                       ovf_i,
  input  logic [3:0]                 crc_i,
  output logic [DATA_NIBS*NIB_W-1:0] data_nibs_o,
  output logic                       frame_valid_o,
  output logic                       crc_error_o,
  output logic                       symbol_error_o,
  output logic [3:0]                 status_o,
  output logic [11:0]                data_a_o,
  output logic [11:0]                data_b_o
);
  localparam int LAST  = DATA_NIBS + 1;  // status + data, checksum excluded
  localparam int IDX_W = $clog2(LAST + 1);
  localparam logic [CNT_W-1:0] SYNC_LO = CNT_W'(SYNC_MIN);
  localparam logic [CNT_W-1:0] SYNC_HI = CNT_W'(SYNC_MAX);
  localparam logic [CNT_W-1:0] SYM_LO  = CNT_W'(NIB_OFS);
  localparam logic [CNT_W-1:0] SYM_HI  = CNT_W'(NIB_LAST);

  rx_state_e                 state_q;
  logic [IDX_W-1:0]          idx_q;
  logic [LAST-1:0][NIB_W-1:0] nib_q;
  logic [3:0]                sym;

  assign sym = per_i[3:0] - 4'(NIB_OFS);

  for (genvar g = 0; g < DATA_NIBS; g++) begin : g_data
    assign data_nibs_o[(DATA_NIBS-g)*NIB_W-1 -: NIB_W] = nib_q[g+1];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q        <= ST_SEARCH;
      idx_q          <= '0;
      nib_q          <= '0;
      frame_valid_o  <= 1'b0;
      crc_error_o    <= 1'b0;
      symbol_error_o <= 1'b0;
      status_o       <= '0;
      data_a_o       <= '0;
      data_b_o       <= '0;
    end else begin
      frame_valid_o  <= 1'b0;
      crc_error_o    <= 1'b0;
      symbol_error_o <= 1'b0;
      if (ovf_i) begin
        state_q <= ST_SEARCH;
      end else if (per_vld_i) begin
        case (state_q)
          ST_SEARCH: begin
            if (per_i >= SYNC_LO && per_i <= SYNC_HI) begin
              state_q <= ST_CAPTURE;
              idx_q   <= '0;
            end
          end
          default: begin
            if (per_i < SYM_LO || per_i > SYM_HI) begin
              symbol_error_o <= 1'b1;
              state_q        <= ST_SEARCH;
            end else if (idx_q == IDX_W'(LAST)) begin
              if (sym == crc_i) begin
                frame_valid_o <= 1'b1;
                status_o      <= nib_q[0];
                data_a_o      <= data_nibs_o[DATA_NIBS*NIB_W-1 -: 12];
                data_b_o      <= data_nibs_o[11:0];
              end else begin
                crc_error_o <= 1'b1;
              end
              state_q <= ST_SEARCH;
            end else begin
              nib_q[idx_q] <= sym;
              idx_q        <= idx_q + 1'b1;
            end
          end
        endcase
      end
    end
  end
endmodule

// File: rtl/sent_rx.sv
module sent_rx
  import sent_rx_pkg::*;
#(
  parameter int SYNC_TICKS = 56,
  parameter int TOL_PCT    = 20,
  parameter int CNT_W      = 8
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        tick_i,
  input  logic        sent_i,
  output logic        frame_valid_o,
  output logic        crc_error_o,
  output logic        symbol_error_o,
  output logic [3:0]  status_o,
  output logic [11:0] data_a_o,
  output logic [11:0] data_b_o
);
  localparam int SYNC_DEV = SYNC_TICKS * TOL_PCT / 100;
  localparam int SYNC_MIN = SYNC_TICKS - SYNC_DEV;
  localparam int SYNC_MAX = SYNC_TICKS + SYNC_DEV;

  logic                       per_vld;
  logic [CNT_W-1:0]           per;
  logic                       ovf;
  logic [DATA_NIBS*NIB_W-1:0] data_nibs;
  logic [3:0]                 crc_calc;

  sent_edge_timer #(.CNT_W(CNT_W)) u_timer (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .tick_i   (tick_i),
    .line_i   (sent_i),
    .per_vld_o(per_vld),
    .per_o    (per),
    .ovf_o    (ovf)
  );

  sent_crc4 #(.NUM(DATA_NIBS)) u_crc (
    .nib_i(data_nibs),
    .crc_o(crc_calc)
  );

  sent_frame_fsm #(
    .CNT_W   (CNT_W),
    .SYNC_MIN(SYNC_MIN),
    .SYNC_MAX(SYNC_MAX)
  ) u_fsm (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .per_vld_i     (per_vld),
    .per_i         (per),
    .ovf_i         (ovf),
    .crc_i         (crc_calc),
    .data_nibs_o   (data_nibs),
    .frame_valid_o (frame_valid_o),
    .crc_error_o   (crc_error_o),
    .symbol_error_o(symbol_error_o),
    .status_o      (status_o),
    .data_a_o      (data_a_o),
    .data_b_o      (data_b_o)
  );
endmodule

// File: rtl/sent_rx_chk.sv
module sent_rx_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        per_vld_i,
  input logic        ovf_i,
  input logic        frame_valid_i,
  input logic        crc_error_i,
  input logic        symbol_error_i,
  input logic [3:0]  status_i,
  input logic [11:0] data_a_i,
  input logic [11:0] data_b_i
);
  // R9
  flags_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({frame_valid_i, crc_error_i, symbol_error_i}));

  // R5
  valid_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_valid_i |=> !frame_valid_i);

  // R6
  crc_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    crc_error_i |=> !crc_error_i);

  // R9
  hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !frame_valid_i |-> $stable({status_i, data_a_i, data_b_i}));

  // R5
  flag_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (frame_valid_i || crc_error_i || symbol_error_i) |-> $past(per_vld_i));

  // R8
  ovf_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf_i |=> !(frame_valid_i || crc_error_i || symbol_error_i));
endmodule

bind sent_rx sent_rx_chk u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .per_vld_i     (per_vld),
  .ovf_i         (ovf),
  .frame_valid_i (frame_valid_o),
  .crc_error_i   (crc_error_o),
  .symbol_error_i(symbol_error_o),
  .status_i      (status_o),
  .data_a_i      (data_a_o),
  .data_b_i      (data_b_o)
);

// File: tb/sent_rx_tb.sv
module sent_rx_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick = 1'b1;
  logic        line = 1'b1;
  logic        fv, ce, se;
  logic [3:0]  st;
  logic [11:0] da, db;

  int n_chk = 0, n_bad = 0;
  int n_fv = 0, n_ce = 0, n_se = 0;
  int tdiv = 1;
  bit done = 1'b0;

  always #10 clk = ~clk;  // 50 MHz

  sent_rx dut_i (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .sent_i(line),
    .frame_valid_o(fv), .crc_error_o(ce), .symbol_error_o(se),
    .status_o(st), .data_a_o(da), .data_b_o(db)
  );

  always @(negedge clk) begin
    if (rst_n) begin
      if (fv) n_fv++;
      if (ce) n_ce++;
      if (se) n_se++;
    end
  end

  // sync, status, six data nibbles, corrupt-checksum flag
  localparam logic [36:0] VEC [7] = '{
    {8'd56, 4'h0, 24'h123456, 1'b0},
    {8'd45, 4'hA, 24'hFFF000, 1'b0},
    {8'd67, 4'h3, 24'h0F0F0F, 1'b0},
    {8'd56, 4'h5, 24'hABCDEF, 1'b1},
    {8'd44, 4'h1, 24'h111111, 1'b0},
    {8'd68, 4'h2, 24'h222222, 1'b0},
    {8'd50, 4'hF, 24'h000000, 1'b0}
  };

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic hold(input logic lvl, input int n);
    line = lvl;
    for (int i = 0; i < n; i++) begin
      tick = 1'b1;
      @(negedge clk);
      tick = (tdiv == 1);
      for (int k = 1; k < tdiv; k++) @(negedge clk);
    end
  endtask

  task automatic pulse(input int w);
    hold(1'b0, 5);
    hold(1'b1, w - 5);
  endtask

  task automatic send_list(input int w[9]);
    for (int i = 0; i < 9; i++) pulse(w[i]);
    pulse(25);  // closing edge and gap
    hold(1'b1, 4);
  endtask

  // long division of {seed, data, 0000} by x^4+x^3+x^2+1
  function automatic logic [3:0] ref_crc(input logic [23:0] d);
    logic [31:0] m;
    logic [3:0]  r;
    logic        fb;
    m = {4'h5, d, 4'h0};
    r = 4'h0;
    for (int i = 31; i >= 0; i--) begin
      fb = r[3];
      r  = {r[2:0], m[i]};
      if (fb) r = r ^ 4'hD;
    end
    return r;
  endfunction

  task automatic send_frame(input int sync, input logic [3:0] s, input logic [23:0] d,
                            input logic [3:0] c);
    int w[9];
    w[0] = sync;
    w[1] = int'(s) + 12;
    for (int i = 0; i < 6; i++) w[2+i] = int'(d[23-4*i -: 4]) + 12;
    w[8] = int'(c) + 12;
    send_list(w);
  endtask

  initial begin
    logic [36:0] e;
    logic [3:0]  es, vs;
    logic [23:0] ed, vd;
    int          sy, f0, c0, s0;
    bit          sok, bad;
    int          w[9];

    es = '0; ed = '0;
    repeat (3) @(negedge clk);
    // R1 during reset
    chk("R1 flags in reset", int'({fv, ce, se}), 0);
    chk("R1 data in reset", int'({st, da, db}), 0);
    rst_n = 1'b1;
    hold(1'b1, 300);
    chk("R1 flags after reset", int'({fv, ce, se}), 0);
    chk("R1 data after reset", int'({st, da, db}), 0);
    chk("R1 no strobes", n_fv + n_ce + n_se, 0);

    for (int v = 0; v < 7; v++) begin
      e   = VEC[v];
      sy  = int'(e[36:29]);
      vs  = e[28:25];
      vd  = e[24:1];
      bad = e[0];
      sok = (sy >= 45 && sy <= 67);
      f0 = n_fv; c0 = n_ce; s0 = n_se;
      send_frame(sy, vs, vd, ref_crc(vd) ^ {3'b000, bad});
      if (sok && !bad) begin es = vs; ed = vd; end
      chk(sok ? "R5 valid count" : "R3 sync rejected", n_fv - f0, int'(sok && !bad));
      chk(sok ? "R6 crc error count" : "R3 no crc error", n_ce - c0, int'(sok && bad));
      chk("R7 no symbol error", n_se - s0, 0);
      chk(bad || !sok ? "R9 status held" : "R4 status", int'(st), int'(es));
      chk(bad || !sok ? "R6 data_a held" : "R4 data_a", int'(da), int'(ed[23:12]));
      chk(bad || !sok ? "R6 data_b held" : "R4 data_b", int'(db), int'(ed[11:0]));
    end

    // R7: symbol too wide, then too narrow, then recovery
    w = '{56, 14, 28, 12, 12, 12, 12, 12, 12};
    f0 = n_fv; s0 = n_se;
    send_list(w);
    chk("R7 wide symbol error", n_se - s0, 1);
    w = '{56, 11, 12, 12, 12, 12, 12, 12, 12};
    send_list(w);
    chk("R7 narrow symbol error", n_se - s0, 2);
    chk("R7 no valid on bad symbols", n_fv - f0, 0);
    send_frame(56, 4'h6, 24'h654321, ref_crc(24'h654321));
    chk("R7 recovery valid", n_fv - f0, 1);
    chk("R7 recovery data_a", int'(da), 'h654);
    es = 4'h6; ed = 24'h654321;

    // R8: counter overflow in the middle of a frame
    f0 = n_fv; c0 = n_ce; s0 = n_se;
    pulse(56); pulse(12 + 3);
    hold(1'b0, 5); hold(1'b1, 300);
    for (int i = 0; i < 7; i++) pulse(12 + i);
    pulse(25); hold(1'b1, 4);
    chk("R8 no strobe after overflow", (n_fv - f0) + (n_ce - c0) + (n_se - s0), 0);
    chk("R8 status held", int'(st), int'(es));

    // R2: two clock cycles per tick
    tdiv = 2;
    f0 = n_fv;
    hold(1'b1, 10);
    send_frame(60, 4'h9, 24'h5A5A5A, ref_crc(24'h5A5A5A));
    chk("R2 slow tick valid", n_fv - f0, 1);
    chk("R2 slow tick status", int'(st), 9);
    chk("R2 slow tick data_b", int'(db), 'hA5A);
    tdiv = 1;

    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule